// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load-Use Stall Unit

This block is the hazard logic of a five-stage in-order integer pipeline with the stages fetch, decode, execute, memory and writeback. The register file is read in decode and written only in writeback. Without bypassing, an instruction that needs the result of the instruction just ahead of it would wait at least two cycles for that producer to reach writeback. This unit removes that wait for ALU producers. It compares the source register numbers of the instruction in execute with the destination registers held in the execute/memory and memory/writeback pipeline registers. For each ALU operand it drives a select that picks the register-file value, the ALU result leaving execute, or the value leaving memory.

A load delivers its data only at the end of the memory stage. A consumer placed directly after a load therefore cannot be served by bypassing. The unit also compares the decode-stage source registers with the destination of a load sitting in execute. On a match it raises a stall, which holds the PC and the fetch/decode register, and a bubble request, which loads the decode/execute register with an all-zero control word. The cost is exactly one cycle, and the load result then reaches the consumer through the memory/writeback bypass.

The unit is purely combinational. All inputs are fields of the pipeline registers, and all outputs are valid in the same cycle. These are control pins with no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `hazard_fwd_unit`

## Requirements
- R1: If the execute/memory stage writes (write enable 1) a nonzero register equal to an execute-stage source, that operand's select is 2'b10 (ALU result from execute/memory).
- R2: If only the memory/writeback stage writes a nonzero register equal to an execute-stage source, that operand's select is 2'b01 (memory/writeback value).
- R3: When both later stages match the same source, the select is 2'b10: the younger result wins.
- R4: With no match, the select is 2'b00 (register file), and the value 2'b11 never appears.
- R5: A destination register number of 0 never produces a bypass select or a stall.
- R6: A stage whose write enable is 0 never produces a bypass select or a stall.
- R7: A load in execute whose nonzero destination equals either decode-stage source raises both the stall output and the bubble output in that cycle.
- R8: A non-load instruction in execute never causes a stall, so a chain of dependent ALU instructions runs with zero bubbles.
- R9: With no load-use match, stall and bubble are both 0. A load followed by one independent instruction and then a consumer costs no bubble.
- R10: The two operand selects are decided independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs1 | input | AW | First source register of the instruction in decode |
| dec_rs2 | input | AW | Second source register of the instruction in decode |
| ex_rs1 | input | AW | First source register of the instruction in execute |
| ex_rs2 | input | AW | Second source register of the instruction in execute |
| ex_rd | input | AW | Destination register of the instruction in execute |
| ex_wen | input | 1 | Register-write enable of the instruction in execute |
| ex_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | AW | Destination held in the execute/memory register |
| mem_wen | input | 1 | Write enable held in the execute/memory register |
| wb_rd | input | AW | Destination held in the memory/writeback register |
| wb_wen | input | 1 | Write enable held in the memory/writeback register |
| stall_front | output | 1 | Hold the PC and the fetch/decode register |
| bubble_ex | output | 1 | Load an all-zero control word into decode/execute |
| sel_a | output | 2 | Bypass select for ALU operand A |
| sel_b | output | 2 | Bypass select for ALU operand B |

## Verification
The bypass selects are tried with a single match in either later stage, with a match in both stages at once, with no match, and with operands that match different stages. These patterns separate the priority order from a plain OR of matches and catch any crossing between the two operands. Register 0 and disabled write enables are driven with otherwise matching numbers, to show that a dependency is not invented where no write happens. Short programs run through a bench-side pipeline model count bubbles: an ALU chain, an immediate load consumer and a consumer two behind a load must cost 0, 1 and 0 cycles respectively.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    BYP_REGFILE = 2'b00,
    BYP_LATE    = 2'b01,
    BYP_EARLY   = 2'b10
  } byp_sel_e;
endpackage

// File: rtl/hzd_dest_match.sv
// One comparison of a source register number against a producing stage.
module hzd_dest_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          wen,
  output logic          hit
);
  logic dst_live;
  assign dst_live = wen && (dst != '0);
  assign hit      = dst_live && (dst == src);
endmodule

// File: rtl/hzd_bypass_sel.sv
// Per-operand bypass select, with the younger producer taking priority.
module hzd_bypass_sel #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] src,
  input  logic [AW-1:0]           early_rd,
  input  logic                    early_wen,
  input  logic [AW-1:0]           late_rd,
  input  logic                    late_wen,
  output hzd_pkg::byp_sel_e       sel [NSRC]
);
  import hzd_pkg::*;

  for (genvar g = 0; g < NSRC; g++) begin : g_op
    logic hit_early;
    logic hit_late;

    hzd_dest_match #(.AW(AW)) u_early (
      .src(src[g]), .dst(early_rd), .wen(early_wen), .hit(hit_early)
    );
    hzd_dest_match #(.AW(AW)) u_late (
      .src(src[g]), .dst(late_rd), .wen(late_wen), .hit(hit_late)
    );

    always_comb begin
      if (hit_early)     sel[g] = BYP_EARLY;
      else if (hit_late) sel[g] = BYP_LATE;
      else               sel[g] = BYP_REGFILE;
    end
  end
endmodule

// File: rtl/hzd_load_use.sv
// Detects a decode-stage consumer of a load that is still in execute.
module hzd_load_use #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] src,
  input  logic [AW-1:0]           ld_rd,
  input  logic                    ld_wen,
  input  logic                    is_load,
  output logic                    stall
);
  logic [NSRC-1:0] hits;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hzd_dest_match #(.AW(AW)) u_cmp (
      .src(src[g]), .dst(ld_rd), .wen(ld_wen), .hit(hits[g])
    );
  end

  assign stall = is_load && (|hits);
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] dec_rs1,
  input  logic [AW-1:0] dec_rs2,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic          stall_front,
  output logic          bubble_ex,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b
);
  import hzd_pkg::*;

  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0] ex_srcs;
  logic [NSRC-1:0][AW-1:0] dec_srcs;
  byp_sel_e                sels [NSRC];
  logic                    lu_stall;

  assign ex_srcs  = {ex_rs2, ex_rs1};
  assign dec_srcs = {dec_rs2, dec_rs1};

  hzd_bypass_sel #(.AW(AW), .NSRC(NSRC)) u_byp (
    .src      (ex_srcs),
    .early_rd (mem_rd),
    .early_wen(mem_wen),
    .late_rd  (wb_rd),
    .late_wen (wb_wen),
    .sel      (sels)
  );

  hzd_load_use #(.AW(AW), .NSRC(NSRC)) u_lu (
    .src    (dec_srcs),
    .ld_rd  (ex_rd),
    .ld_wen (ex_wen),
    .is_load(ex_load),
    .stall  (lu_stall)
  );

  assign sel_a       = sels[0];
  assign sel_b       = sels[1];
  assign stall_front = lu_stall;
  assign bubble_ex   = lu_stall;
endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk #(
  parameter int AW = 5
) (
  input logic [AW-1:0] dec_rs1,
  input logic [AW-1:0] dec_rs2,
  input logic [AW-1:0] ex_rs1,
  input logic [AW-1:0] ex_rs2,
  input logic [AW-1:0] ex_rd,
  input logic          ex_wen,
  input logic          ex_load,
  input logic [AW-1:0] mem_rd,
  input logic          mem_wen,
  input logic [AW-1:0] wb_rd,
  input logic          wb_wen,
  input logic          stall_front,
  input logic          bubble_ex,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b
);
  logic mem_live, wb_live;
  assign mem_live = mem_wen && (mem_rd != '0);
  assign wb_live  = wb_wen && (wb_rd != '0);

  always_comb begin
    assert_early_a_R1: assert (!(mem_live && mem_rd == ex_rs1) || sel_a == 2'b10)
      else $error("operand A missed execute/memory result");
    assert_early_b_R3: assert (!(mem_live && mem_rd == ex_rs2) || sel_b == 2'b10)
      else $error("operand B missed execute/memory priority");
    assert_late_a_R2: assert (!(wb_live && wb_rd == ex_rs1 && !(mem_live && mem_rd == ex_rs1))
                              || sel_a == 2'b01)
      else $error("operand A missed memory/writeback value");
    assert_legal_sel_R4: assert (sel_a != 2'b11 && sel_b != 2'b11)
      else $error("illegal bypass select");
    assert_dead_dest_R6: assert ((mem_live || wb_live) || (sel_a == 2'b00 && sel_b == 2'b00))
      else $error("bypass without a live producer");
    assert_alu_nostall_R8: assert (ex_load || !stall_front)
      else $error("stall without a load in execute");
    assert_pair_R7: assert (stall_front == bubble_ex)
      else $error("stall and bubble disagree");
  end
endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/hazard_fwd_unit_tb.sv
`timescale 1ns/1ps
module hazard_fwd_unit_tb;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_wen, ex_load, mem_wen, wb_wen;
  logic stall_front, bubble_ex;
  logic [1:0] sel_a, sel_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  hazard_fwd_unit #(.AW(AW)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    dec_rs1 = 0; dec_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
    ex_wen = 0; ex_load = 0; mem_rd = 0; mem_wen = 0; wb_rd = 0; wb_wen = 0;
  endtask

  task automatic t_idle();
    @(negedge clk); clr(); #1;
    chk("R4 idle sel_a", sel_a, 0); chk("R4 idle sel_b", sel_b, 0);
    chk("R9 idle stall", stall_front, 0); chk("R9 idle bubble", bubble_ex, 0);
  endtask

  task automatic t_early();
    @(negedge clk); clr();
    ex_rs1 = 7; ex_rs2 = 9; mem_rd = 7; mem_wen = 1; #1;
    chk("R1 early A", sel_a, 2); chk("R1 other B", sel_b, 0);
    ex_rs1 = 3; ex_rs2 = 7; #1;
    chk("R1 early B", sel_b, 2); chk("R1 other A", sel_a, 0);
  endtask

  task automatic t_late();
    @(negedge clk); clr();
    ex_rs1 = 12; ex_rs2 = 12; wb_rd = 12; wb_wen = 1; mem_rd = 4; mem_wen = 1; #1;
    chk("R2 late A", sel_a, 1); chk("R2 late B", sel_b, 1);
  endtask

  task automatic t_both();
    @(negedge clk); clr();
    ex_rs1 = 5; ex_rs2 = 5; mem_rd = 5; mem_wen = 1; wb_rd = 5; wb_wen = 1; #1;
    chk("R3 priority A", sel_a, 2); chk("R3 priority B", sel_b, 2);
  endtask

  task automatic t_nomatch();
    @(negedge clk); clr();
    ex_rs1 = 1; ex_rs2 = 2; mem_rd = 3; mem_wen = 1; wb_rd = 4; wb_wen = 1; #1;
    chk("R4 nomatch A", sel_a, 0); chk("R4 nomatch B", sel_b, 0);
  endtask

  task automatic t_zero();
    @(negedge clk); clr();
    mem_wen = 1; wb_wen = 1; ex_wen = 1; ex_load = 1; #1;
    chk("R5 zero A", sel_a, 0); chk("R5 zero B", sel_b, 0);
    chk("R5 zero stall", stall_front, 0);
  endtask

  task automatic t_wen();
    @(negedge clk); clr();
    ex_rs1 = 8; ex_rs2 = 8; mem_rd = 8; wb_rd = 8;
    dec_rs1 = 8; ex_rd = 8; ex_load = 1; #1;
    chk("R6 wen0 A", sel_a, 0); chk("R6 wen0 B", sel_b, 0);
    chk("R6 wen0 stall", stall_front, 0);
  endtask

  task automatic t_loaduse();
    @(negedge clk); clr();
    ex_rd = 6; ex_wen = 1; ex_load = 1; dec_rs1 = 6; dec_rs2 = 2; #1;
    chk("R7 rs1 stall", stall_front, 1); chk("R7 rs1 bubble", bubble_ex, 1);
    dec_rs1 = 2; dec_rs2 = 6; #1;
    chk("R7 rs2 stall", stall_front, 1); chk("R7 rs2 bubble", bubble_ex, 1);
    dec_rs2 = 11; #1;
    chk("R9 load other", stall_front, 0); chk("R9 load other bubble", bubble_ex, 0);
  endtask

  task automatic t_alu();
    @(negedge clk); clr();
    ex_rd = 6; ex_wen = 1; dec_rs1 = 6; dec_rs2 = 6; #1;
    chk("R8 alu nostall", stall_front, 0);
  endtask

  task automatic t_indep();
    @(negedge clk); clr();
    ex_rs1 = 10; ex_rs2 = 20; mem_rd = 20; mem_wen = 1; wb_rd = 10; wb_wen = 1; #1;
    chk("R10 A late", sel_a, 1); chk("R10 B early", sel_b, 2);
  endtask

  // Program run through a bench-side five-stage model; returns bubble count.
  task automatic run_prog(input string req, input int n, input int rd[4], input int s1[4],
                          input int s2[4], input bit ld[4], input int exp_bub);
    int pc = 0; int d = -1; int e = -1; int m = -1; int w = -1;
    int bub = 0; int retired = 0; int cyc = 0;
    while (retired < n && cyc < 50) begin
      @(negedge clk); clr();
      if (d >= 0) begin dec_rs1 = rd[0][AW-1:0] & 0; dec_rs1 = s1[d][AW-1:0]; dec_rs2 = s2[d][AW-1:0]; end
      if (e >= 0) begin ex_rs1 = s1[e][AW-1:0]; ex_rs2 = s2[e][AW-1:0];
                        ex_rd = rd[e][AW-1:0]; ex_wen = 1; ex_load = ld[e]; end
      if (m >= 0) begin mem_rd = rd[m][AW-1:0]; mem_wen = 1; end
      if (w >= 0) begin wb_rd = rd[w][AW-1:0]; wb_wen = 1; end
      #1;
      if (stall_front) bub++;
      @(posedge clk);
      if (w >= 0) retired++;
      w = m; m = e;
      if (stall_front) e = -1;
      else begin e = d; d = (pc < n) ? pc : -1; if (pc < n) pc++; end
      cyc++;
    end
    chk(req, bub, exp_bub);
  endtask

  task automatic t_pipe();
    int rd[4]; int s1[4]; int s2[4]; bit ld[4];
    rd = '{1, 2, 3, 4}; s1 = '{0, 1, 2, 3}; s2 = '{0, 1, 1, 2}; ld = '{0, 0, 0, 0};
    run_prog("R8 alu chain bubbles", 4, rd, s1, s2, ld, 0);
    rd = '{1, 2, 3, 4}; s1 = '{0, 1, 9, 9}; s2 = '{0, 0, 9, 9}; ld = '{1, 0, 0, 0};
    run_prog("R7 load-use bubbles", 4, rd, s1, s2, ld, 1);
    rd = '{1, 2, 3, 4}; s1 = '{0, 9, 1, 9}; s2 = '{0, 9, 9, 9}; ld = '{1, 0, 0, 0};
    run_prog("R9 distance-two bubbles", 4, rd, s1, s2, ld, 0);
  endtask

  initial begin
    clr();
    t_idle(); t_early(); t_late(); t_both(); t_nomatch(); t_zero();
    t_wen(); t_loaduse(); t_alu(); t_indep(); t_pipe();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule